// File: doc/BRIEF.md
# DMA interrupt status clear unit

This block keeps the interrupt status of a twelve-channel DMA controller. Every channel has five flags: error, done, half-way, block end and a summary (global) flag. Channel logic reports events through one-cycle pulse inputs. Any error, done, half-way or block-end pulse also sets that channel's summary flag. Software reads the flags through two read-only status words. It removes them by writing ones to two clear words. The clear words are strobes: they store nothing and always read as zero.

Both kinds of word give each channel a five-bit group. Channel n sits in group n mod 6, in bits (n mod 6)*5+4 down to (n mod 6)*5. Within a group, +4 is error, +3 is done, +2 is half-way, +1 is block end and +0 is summary. Word 0 covers channels 0 to 5 and word 1 covers channels 6 to 11. Bits 31:30 are always zero.

The words are at these offsets:
- status word 0 at 0x120
- status word 1 at 0x124
- clear word 0 at 0x128
- clear word 1 at 0x12C

Writing 1 to a channel's summary clear bit removes all five of its flags. The interrupt output is driven by a two-state machine. In IRQ_IDLE the machine takes the "raise" transition to IRQ_PENDING on any clock edge where some summary flag is set. In IRQ_PENDING it takes the "drop" transition back to IRQ_IDLE on an edge where no summary flag is set. The output is high exactly while the machine is in IRQ_PENDING.

Top module: `dmaisc_top`

## Requirements
- R1: After reset, both status words read 0, both clear words read 0 and irq is 0.
- R2: A pulse on evt_err, evt_done, evt_half or evt_blk for channel n sets, at the next clock edge, the matching flag and the summary flag of channel n. The flags appear in status word n/6 (0x120 or 0x124) at bits (n mod 6)*5 + 4/3/2/1 and +0 respectively.
- R3: A write of 1 to an error, done, half-way or block-end bit of a clear word (0x128 for channels 0-5, 0x12C for channels 6-11, same bit layout) clears only that flag at the next edge. All other flags are unchanged.
- R4: Clear-word bits written as 0 change no flag.
- R5: A write of 1 to a channel's summary clear bit (+0) clears all five flags of that channel at the next edge.
- R6: When a set pulse and a clear meet on the same flag in the same cycle, the flag ends up set.
- R7: Reading either clear word returns 0.
- R8: Writes to the status words or to any unmapped address change no flag.
- R9: irq after each edge equals the OR of all summary flags as they were before that edge. It therefore rises one cycle after the first summary flag and falls one cycle after the last one is cleared.
- R10: Clearing an error, done, half-way or block-end flag leaves the channel's summary flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_err | input | 12 | Per-channel error event pulses |
| evt_done | input | 12 | Per-channel done event pulses |
| evt_half | input | 12 | Per-channel half-way event pulses |
| evt_blk | input | 12 | Per-channel block-end event pulses |
| wr_en | input | 1 | Write strobe for bus_addr/wr_data |
| bus_addr | input | 12 | Byte address for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that:
- event pulses land in the flags one edge later, even against a clear;
- a summary clear empties its channel;
- flags hold still when no event arrives and no clear word is written;
- clear words read zero;
- irq follows the summary OR with a one-cycle lag.

Only the bench scenarios can show that each flag appears at its exact bit in the right status word. They also show that an individual clear leaves the neighbouring bits and the summary flag alone, and that writes of ones to status or unmapped addresses are discarded.

// File: rtl/dmaisc_pkg.sv
package dmaisc_pkg;
    localparam int FLAGS_PER_CH = 5;
    localparam int BIT_ERR  = 4;
    localparam int BIT_DONE = 3;
    localparam int BIT_HALF = 2;
    localparam int BIT_BLK  = 1;
    localparam int BIT_GLOB = 0;

    // Field order matches the bit order inside one channel group.
    typedef struct packed {
        logic err;
        logic done;
        logic half;
        logic blk;
        logic glob;
    } ch_flags_t;

    typedef enum logic {
        IRQ_IDLE    = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_t;
endpackage

// File: rtl/dmaisc_chan.sv
module dmaisc_chan
    import dmaisc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    set_err,
    input  logic                    set_done,
    input  logic                    set_half,
    input  logic                    set_blk,
    input  logic [FLAGS_PER_CH-1:0] clr,
    output ch_flags_t               flags
);
    logic clr_all;
    logic set_any;

    assign clr_all = clr[BIT_GLOB];
    assign set_any = set_err | set_done | set_half | set_blk;

    // Set has priority over clear so that no event is lost.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags.err  <= set_err  | (flags.err  & ~(clr[BIT_ERR]  | clr_all));
            flags.done <= set_done | (flags.done & ~(clr[BIT_DONE] | clr_all));
            flags.half <= set_half | (flags.half & ~(clr[BIT_HALF] | clr_all));
            flags.blk  <= set_blk  | (flags.blk  & ~(clr[BIT_BLK]  | clr_all));
            flags.glob <= set_any  | (flags.glob & ~clr_all);
        end
    end
endmodule

// File: rtl/dmaisc_regdec.sv
module dmaisc_regdec #(
    parameter int NUM_REGS  = 2,
    parameter int REG_BITS  = 30,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int STAT_BASE = 'h120,
    parameter int CLR_BASE  = 'h128
) (
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [NUM_REGS*REG_BITS-1:0] stat_vec,
    output logic [NUM_REGS*REG_BITS-1:0] clr_vec,
    output logic [DATA_W-1:0]            rd_data
);
    localparam int PAD_W = DATA_W - REG_BITS;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wr_data[DATA_W-1:REG_BITS];

    // Clear words are write strobes only; a write of 1 lasts one cycle.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_clr
        logic hit;
        assign hit = wr_en && (bus_addr == ADDR_W'(CLR_BASE + 4*r));
        assign clr_vec[r*REG_BITS +: REG_BITS] = hit ? wr_data[REG_BITS-1:0] : '0;
    end

    // Only status words return data; clear words and holes read zero.
    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (bus_addr == ADDR_W'(STAT_BASE + 4*r)) begin
                rd_data = {{PAD_W{1'b0}}, stat_vec[r*REG_BITS +: REG_BITS]};
            end
        end
    end
endmodule

// File: rtl/dmaisc_irq.sv
module dmaisc_irq
    import dmaisc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_glob,
    output logic irq
);
    irq_state_t state_q;
    irq_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:    if (any_glob)  state_d = IRQ_PENDING; // raise
            IRQ_PENDING: if (!any_glob) state_d = IRQ_IDLE;    // drop
            default:     state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_PENDING);
    end
endmodule

// File: rtl/dmaisc_top.sv
module dmaisc_top
    import dmaisc_pkg::*;
#(
    parameter int NUM_CH     = 12,
    parameter int CH_PER_REG = 6,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int STAT_BASE  = 'h120,
    parameter int CLR_BASE   = 'h128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_err,
    input  logic [NUM_CH-1:0] evt_done,
    input  logic [NUM_CH-1:0] evt_half,
    input  logic [NUM_CH-1:0] evt_blk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int NUM_REGS = (NUM_CH + CH_PER_REG - 1) / CH_PER_REG;
    localparam int REG_BITS = CH_PER_REG * FLAGS_PER_CH;
    localparam int VEC_BITS = NUM_REGS * REG_BITS;

    logic [VEC_BITS-1:0] stat_vec;
    logic [VEC_BITS-1:0] clr_vec;
    ch_flags_t           flags_q [NUM_CH];
    logic [NUM_CH-1:0]   err_q, done_q, half_q, blk_q, glob_q;

    dmaisc_regdec #(
        .NUM_REGS(NUM_REGS), .REG_BITS(REG_BITS), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .STAT_BASE(STAT_BASE), .CLR_BASE(CLR_BASE)
    ) u_dec (
        .wr_en(wr_en), .bus_addr(bus_addr), .wr_data(wr_data),
        .stat_vec(stat_vec), .clr_vec(clr_vec), .rd_data(rd_data)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dmaisc_chan u_ch (
            .clk(clk), .rst_n(rst_n),
            .set_err(evt_err[c]), .set_done(evt_done[c]),
            .set_half(evt_half[c]), .set_blk(evt_blk[c]),
            .clr(clr_vec[c*FLAGS_PER_CH +: FLAGS_PER_CH]),
            .flags(flags_q[c])
        );
        assign stat_vec[c*FLAGS_PER_CH +: FLAGS_PER_CH] = flags_q[c];
        assign err_q[c]  = flags_q[c].err;
        assign done_q[c] = flags_q[c].done;
        assign half_q[c] = flags_q[c].half;
        assign blk_q[c]  = flags_q[c].blk;
        assign glob_q[c] = flags_q[c].glob;
    end

    if (VEC_BITS > NUM_CH * FLAGS_PER_CH) begin : g_tail
        assign stat_vec[VEC_BITS-1:NUM_CH*FLAGS_PER_CH] = '0;
    end

    dmaisc_irq u_irq (
        .clk(clk), .rst_n(rst_n), .any_glob(|glob_q), .irq(irq)
    );
endmodule

// File: rtl/dmaisc_chk.sv
module dmaisc_chk #(
    parameter int NUM_CH     = 12,
    parameter int CH_PER_REG = 6,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int CLR_BASE   = 'h128
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] evt_err,
    input logic [NUM_CH-1:0] evt_done,
    input logic [NUM_CH-1:0] evt_half,
    input logic [NUM_CH-1:0] evt_blk,
    input logic              wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq,
    input logic [NUM_CH-1:0] err_q,
    input logic [NUM_CH-1:0] done_q,
    input logic [NUM_CH-1:0] half_q,
    input logic [NUM_CH-1:0] blk_q,
    input logic [NUM_CH-1:0] glob_q
);
    localparam int NUM_REGS = (NUM_CH + CH_PER_REG - 1) / CH_PER_REG;

    logic              at_clr;
    logic [NUM_CH-1:0] any_evt;
    logic [5*NUM_CH-1:0] all_flags;

    always_comb begin
        at_clr = 1'b0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (bus_addr == ADDR_W'(CLR_BASE + 4*r)) at_clr = 1'b1;
        end
    end
    assign any_evt   = evt_err | evt_done | evt_half | evt_blk;
    assign all_flags = {err_q, done_q, half_q, blk_q, glob_q};

    assert_set_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_q  & $past(evt_err))  == $past(evt_err))
              && ((done_q & $past(evt_done)) == $past(evt_done))
              && ((half_q & $past(evt_half)) == $past(evt_half))
              && ((blk_q  & $past(evt_blk))  == $past(evt_blk)));

    assert_glob_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((glob_q & $past(any_evt)) == $past(any_evt)));

    assert_quiet_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && at_clr) && (any_evt == '0)) |=> $stable(all_flags));

    assert_clr_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        at_clr |-> (rd_data == '0));

    assert_irq_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|glob_q)));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_gclr
        localparam int CADDR = CLR_BASE + 4 * (c / CH_PER_REG);
        localparam int GBIT  = (c % CH_PER_REG) * 5;
        logic gclr;
        assign gclr = wr_en && (bus_addr == ADDR_W'(CADDR)) && wr_data[GBIT];
        assert_glob_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (gclr && !any_evt[c]) |=>
                !err_q[c] && !done_q[c] && !half_q[c] && !blk_q[c] && !glob_q[c]);
    end
endmodule

bind dmaisc_top dmaisc_chk #(
    .NUM_CH(NUM_CH), .CH_PER_REG(CH_PER_REG), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .CLR_BASE(CLR_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .evt_err(evt_err), .evt_done(evt_done), .evt_half(evt_half), .evt_blk(evt_blk),
    .wr_en(wr_en), .bus_addr(bus_addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq),
    .err_q(err_q), .done_q(done_q), .half_q(half_q), .blk_q(blk_q), .glob_q(glob_q)
);

// File: tb/sim_dmaisc_top.sv
module sim_dmaisc_top;
    localparam logic [11:0] A_STAT0 = 12'h120;
    localparam logic [11:0] A_STAT1 = 12'h124;
    localparam logic [11:0] A_CLR0  = 12'h128;
    localparam logic [11:0] A_CLR1  = 12'h12C;
    localparam logic [11:0] A_HOLE  = 12'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] evt_err = '0, evt_done = '0, evt_half = '0, evt_blk = '0;
    logic        wr_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [11:0] m_err = '0, m_done = '0, m_half = '0, m_blk = '0, m_glob = '0;
    logic        m_irq = 1'b0;

    always #5 clk = ~clk;

    dmaisc_top u0 (
        .clk(clk), .rst_n(rst_n),
        .evt_err(evt_err), .evt_done(evt_done), .evt_half(evt_half), .evt_blk(evt_blk),
        .wr_en(wr_en), .bus_addr(bus_addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [31:0] exp_word(int r);
        logic [31:0] v = '0;
        for (int c = 0; c < 6; c++) begin
            int ch = r * 6 + c;
            v[c*5+4] = m_err[ch];
            v[c*5+3] = m_done[ch];
            v[c*5+2] = m_half[ch];
            v[c*5+1] = m_blk[ch];
            v[c*5+0] = m_glob[ch];
        end
        return v;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_at(logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic check_state(string tag);
        logic [31:0] v;
        read_at(A_STAT0, v); chk(tag, v, exp_word(0));
        read_at(A_STAT1, v); chk(tag, v, exp_word(1));
        chk("R9", {31'b0, irq}, {31'b0, m_irq});
    endtask

    // Drive one cycle at the falling edge, update the model at the rising edge.
    task automatic step(logic [11:0] e_err, logic [11:0] e_done, logic [11:0] e_half,
                        logic [11:0] e_blk, logic wr, logic [11:0] a, logic [31:0] d);
        logic [4:0] cl;
        evt_err = e_err; evt_done = e_done; evt_half = e_half; evt_blk = e_blk;
        wr_en = wr; bus_addr = a; wr_data = d;
        @(posedge clk);
        m_irq = |m_glob;
        for (int ch = 0; ch < 12; ch++) begin
            cl = '0;
            if (wr && a == (ch < 6 ? A_CLR0 : A_CLR1)) cl = d[(ch%6)*5 +: 5];
            m_err[ch]  = e_err[ch]  | (m_err[ch]  & ~(cl[4] | cl[0]));
            m_done[ch] = e_done[ch] | (m_done[ch] & ~(cl[3] | cl[0]));
            m_half[ch] = e_half[ch] | (m_half[ch] & ~(cl[2] | cl[0]));
            m_blk[ch]  = e_blk[ch]  | (m_blk[ch]  & ~(cl[1] | cl[0]));
            m_glob[ch] = (e_err[ch] | e_done[ch] | e_half[ch] | e_blk[ch]) | (m_glob[ch] & ~cl[0]);
        end
        @(negedge clk);
        evt_err = '0; evt_done = '0; evt_half = '0; evt_blk = '0; wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [11:0] addrs [5];
        addrs[0] = A_STAT0; addrs[1] = A_STAT1; addrs[2] = A_CLR0;
        addrs[3] = A_CLR1;  addrs[4] = A_HOLE;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_state("R1");
        read_at(A_CLR0, v); chk("R1", v, 32'h0);
        // R2: error on channel 0 -> bits 4 and 0 of word 0
        step(12'h001, 0, 0, 0, 0, A_HOLE, 0);
        check_state("R2");
        read_at(A_STAT0, v); chk("R2", v, 32'h0000_0011);
        step(0, 0, 0, 0, 0, A_HOLE, 0);
        chk("R9", {31'b0, irq}, 32'd1);
        // R2: half-way on channel 11 -> bits 27 and 25 of word 1
        step(0, 0, 12'h800, 0, 0, A_HOLE, 0);
        read_at(A_STAT1, v); chk("R2", v, 32'h0A00_0000);
        // R2: done ch7, block end ch3
        step(0, 12'h080, 0, 12'h008, 0, A_HOLE, 0);
        check_state("R2");
        // R7: clear words read zero with flags set
        read_at(A_CLR0, v); chk("R7", v, 32'h0);
        read_at(A_CLR1, v); chk("R7", v, 32'h0);
        // R4: writing zeros to a clear word
        step(0, 0, 0, 0, 1, A_CLR0, 32'h0);
        check_state("R4");
        // R8: ones to status and unmapped addresses are ignored
        step(0, 0, 0, 0, 1, A_STAT0, 32'hFFFF_FFFF);
        step(0, 0, 0, 0, 1, A_STAT1, 32'hFFFF_FFFF);
        step(0, 0, 0, 0, 1, A_HOLE,  32'hFFFF_FFFF);
        check_state("R8");
        // R3 / R10: clear error of channel 0, summary remains
        step(0, 0, 0, 0, 1, A_CLR0, 32'h0000_0010);
        check_state("R3");
        read_at(A_STAT0, v); chk("R10", v & 32'h1F, 32'h0000_0001);
        // R6: set and clear on channel 7 done in the same cycle
        step(0, 12'h080, 0, 0, 1, A_CLR1, 32'h0000_0100);
        check_state("R6");
        // R5: summary clear of channel 11 drops all five flags
        step(0, 0, 0, 0, 1, A_CLR1, 32'h0200_0000);
        check_state("R5");
        read_at(A_STAT1, v); chk("R5", v & 32'h3E00_0000, 32'h0);
        // R9: clear everything, irq falls one cycle later
        step(0, 0, 0, 0, 1, A_CLR0, 32'h3FFF_FFFF);
        step(0, 0, 0, 0, 1, A_CLR1, 32'h3FFF_FFFF);
        chk("R9", {31'b0, irq}, 32'd1);
        step(0, 0, 0, 0, 0, A_HOLE, 0);
        chk("R9", {31'b0, irq}, 32'd0);
        check_state("R9");
        // Random mix
        for (int i = 0; i < 400; i++) begin
            step(12'($urandom & $urandom & $urandom), 12'($urandom & $urandom & $urandom),
                 12'($urandom & $urandom & $urandom), 12'($urandom & $urandom & $urandom),
                 1'($urandom), addrs[$urandom % 5], $urandom & $urandom);
            check_state("R3");
        end
        finish_run();
    end
endmodule